// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block lets a host read a fixed table of configuration items without any write path into the table. The host first writes a 16-bit key, which chooses one item, and then pulls that item out byte by byte through a data access. A read offset inside the block starts at zero on every key write and moves forward by one for each byte delivered. When the offset reaches the end of the item, further bytes come back as zero.

Items live in an on-chip read-only table split into a generic bank and an architecture-local bank. Each item has a base address into a flat byte store and a length. Two bus views share one request interface. The combined view has a 16-bit selector and a single-byte data port. The split view has a selector window and a data window that accepts reads 1 to `DATA_BYTES` wide. A wide read packs its bytes so that the first byte fetched is the most significant.

Requests are handled by a three-state machine:
- `ST_IDLE` waits for `req_i`. A data read moves to `ST_SHIFT`. Every other access, including a select, moves straight to `ST_REPLY`.
- `ST_SHIFT` fetches one byte per cycle. It moves to `ST_REPLY` after the last byte.
- `ST_REPLY` raises `ack_o` for one cycle and returns to `ST_IDLE`.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset, the selection is key 0 with offset 0, so the first one-byte read returns the byte at offset 0 of generic entry 0 (value 8'h0B).
- R2: A select access stores the key and sets the read offset to zero.
- R3: Key bit 14 chooses the architecture-local bank (1) or the generic bank (0). Key bits 13:0 give the entry index. Key bit 15 has no effect. An index of `N_ENTRIES` (8) or more makes the selection invalid.
- R4: A byte fetch returns 0 and leaves the offset unchanged when the selection is invalid, when the entry length is zero, or when the offset equals the entry length.
- R5: A byte fetch from a valid selection returns the table byte at the current offset, and the offset then increases by one.
- R6: A data read of N bytes performs N sequential fetches. The result is right-aligned in `rdata_o`, and the first fetched byte occupies bits 8N-1:8N-8.
- R7: Combined view: `addr_i`=0 with a 2-byte write is a select, using `wdata_i[15:0]` as the key. `addr_i`=1 with size 1 is a data access. Any other access to these two addresses is rejected.
- R8: Split view: `addr_i`=2 with a 2-byte write is a select. `addr_i`=3 with a read of size 1 to `DATA_BYTES` (4) is a data read. Any other access to these two addresses is rejected.
- R9: A write to either data address is ignored. It changes neither the key nor the offset, and it returns 0.
- R10: A rejected access completes with `rdata_o`=0 and has no effect on the key or the offset.
- R11: Table contents:
  - Entry e of bank b has length 0 when e=2, and e+1+b otherwise.
  - Entries are laid out back to back: bank 0 entries 0..7 first, then bank 1 entries 0..7. The base of an entry is the sum of the lengths of all entries before it.
  - The byte at flat address a is (29a+11) mod 256.
- R12: Every accepted request produces exactly one `ack_o` pulse, one cycle long, and `rdata_o` is valid during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | One-cycle request strobe, taken only in `ST_IDLE` |
| wr_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 2 | 0: combined selector, 1: combined data, 2: split selector, 3: split data |
| size_i | input | 3 | Access width in bytes |
| wdata_i | input | 16 | Key for select writes |
| ack_o | output | 1 | Completion pulse |
| rdata_o | output | 32 | Read result, right-aligned |

## Verification
The bench targets these corner cases, each paired with the failure it would expose:
- **End of an item.** A wide read that crosses the end of an item must return zeros in its low bytes. A design with a wrong end compare would leak bytes from the next item.
- **Empty and invalid keys.** An empty entry and an out-of-range index must both read as zero. A design that still advanced the offset would lose bytes after a reselection.
- **Rejected and ignored accesses.** These are placed in the middle of a partly read item, and the next read must continue from the same offset. A design that treated a one-byte write to the selector as a select, or that reset the offset, would fail this.
- **Bit 15 and the bank bit.** Both are exercised. A key decoder that used bit 15 would misread key C000.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_REPLY = 2'd2
    } eng_state_t;

    typedef enum logic [1:0] {
        ACC_REJECT = 2'd0,
        ACC_SELECT = 2'd1,
        ACC_READ   = 2'd2,
        ACC_IGNORE = 2'd3
    } acc_kind_t;

    localparam logic [15:0] KEY_INVALID = 16'hFFFF;
    localparam int          LOCAL_BIT   = 14;

    // Length of entry idx in bank: slot 2 is left empty in both banks.
    function automatic int item_len(int bank, int idx);
        return (idx == 2) ? 0 : idx + 1 + bank;
    endfunction

    // Flat base address: bank 0 entries first, then bank 1, packed back to back.
    function automatic int item_base(int bank, int idx, int n_entries);
        int sum;
        sum = 0;
        for (int b = 0; b < 2; b++) begin
            for (int e = 0; e < n_entries; e++) begin
                if (b < bank || (b == bank && e < idx)) begin
                    sum += item_len(b, e);
                end
            end
        end
        return sum;
    endfunction

    function automatic logic [7:0] rom_byte(int a);
        return 8'((a * 29 + 11) % 256);
    endfunction

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
    import cfgport_pkg::*;
#(
    parameter int DATA_BYTES = 4
) (
    input  logic      wr_i,
    input  logic [1:0] addr_i,
    input  logic [2:0] size_i,
    output acc_kind_t kind_o
);

    always_comb begin
        kind_o = ACC_REJECT;
        unique case (addr_i)
            2'd0: kind_o = (wr_i && size_i == 3'd2) ? ACC_SELECT : ACC_REJECT;
            2'd1: begin
                if (size_i == 3'd1) kind_o = wr_i ? ACC_IGNORE : ACC_READ;
                else                kind_o = ACC_REJECT;
            end
            2'd2: kind_o = (wr_i && size_i == 3'd2) ? ACC_SELECT : ACC_REJECT;
            2'd3: begin
                if (size_i >= 3'd1 && size_i <= 3'(DATA_BYTES)) kind_o = wr_i ? ACC_IGNORE : ACC_READ;
                else                                             kind_o = ACC_REJECT;
            end
            default: kind_o = ACC_REJECT;
        endcase
    end

endmodule

// File: rtl/cfgport_table.sv
module cfgport_table
    import cfgport_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int OFF_W     = 8
) (
    input  logic [15:0]      key_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [7:0]       byte_o,
    output logic             valid_o
);

    localparam int IDX_W     = $clog2(N_ENTRIES);
    localparam int TOTAL     = item_base(2, 0, N_ENTRIES);
    localparam int ADDR_W    = $clog2(TOTAL);
    localparam int ROM_DEPTH = 1 << ADDR_W;

    logic [7:0]        rom      [ROM_DEPTH];
    logic [OFF_W-1:0]  len_tab  [2][N_ENTRIES];
    logic [ADDR_W-1:0] base_tab [2][N_ENTRIES];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
            assign len_tab[b][e]  = OFF_W'(item_len(b, e));
            assign base_tab[b][e] = ADDR_W'(item_base(b, e, N_ENTRIES));
        end
    end

    for (genvar a = 0; a < ROM_DEPTH; a++) begin : g_rom
        assign rom[a] = rom_byte(a);
    end

    logic              bank;
    logic [IDX_W-1:0]  idx;
    logic [OFF_W-1:0]  len;
    logic [ADDR_W-1:0] flat;

    always_comb begin
        bank    = key_i[LOCAL_BIT];
        idx     = key_i[IDX_W-1:0];
        len     = len_tab[bank][idx];
        flat    = base_tab[bank][idx] + ADDR_W'(off_i);
        valid_o = (key_i != KEY_INVALID) && (len != '0) && (off_i < len);
        byte_o  = valid_o ? rom[flat] : 8'h00;
    end

    // R11: a valid fetch never addresses beyond the populated store
    always_comb begin
        if (valid_o) begin
            assert_fetch_in_store_R11: assert (int'(flat) < TOTAL);
        end
    end

endmodule

// File: rtl/cfgport_engine.sv
module cfgport_engine
    import cfgport_pkg::*;
#(
    parameter int N_ENTRIES  = 8,
    parameter int DATA_BYTES = 4,
    parameter int OFF_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_i,
    input  acc_kind_t               kind_i,
    input  logic [2:0]              size_i,
    input  logic [15:0]             wdata_i,
    input  logic [7:0]              byte_i,
    input  logic                    byte_valid_i,
    output logic [15:0]             key_o,
    output logic [OFF_W-1:0]        off_o,
    output logic                    ack_o,
    output logic [DATA_BYTES*8-1:0] rdata_o
);

    localparam int ACC_W = DATA_BYTES * 8;
    localparam int CNT_W = $clog2(DATA_BYTES + 1);

    eng_state_t        state_q, state_d;
    logic [15:0]       key_q;
    logic [OFF_W-1:0]  off_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ACC_W-1:0]  acc_q;
    logic              take;
    logic              key_ok;

    assign take   = (state_q == ST_IDLE) && req_i;
    assign key_ok = wdata_i[13:0] < 14'(N_ENTRIES);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_i) state_d = (kind_i == ACC_READ) ? ST_SHIFT : ST_REPLY;
            ST_SHIFT: if (cnt_q == CNT_W'(1)) state_d = ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= 16'h0000;
            off_q <= '0;
            cnt_q <= '0;
            acc_q <= '0;
        end else begin
            if (take) begin
                acc_q <= '0;
                cnt_q <= CNT_W'(size_i);
                if (kind_i == ACC_SELECT) begin
                    key_q <= key_ok ? wdata_i : KEY_INVALID;
                    off_q <= '0;
                end
            end else if (state_q == ST_SHIFT) begin
                acc_q <= {acc_q[ACC_W-9:0], byte_i};
                cnt_q <= cnt_q - CNT_W'(1);
                if (byte_valid_i) off_q <= off_q + OFF_W'(1);
            end
        end
    end

    always_comb begin
        ack_o   = (state_q == ST_REPLY);
        rdata_o = acc_q;
        key_o   = key_q;
        off_o   = off_q;
    end

    assert_sel_clears_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind_i == ACC_SELECT) |=> (off_q == '0));

    assert_key_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_q == KEY_INVALID) || (key_q[13:0] < 14'(N_ENTRIES)));

    assert_hold_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !byte_valid_i) |=> $stable(off_q));

    assert_step_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && byte_valid_i) |=> (off_q == $past(off_q) + OFF_W'(1)));

    assert_reject_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind_i != ACC_READ) |=> (ack_o && rdata_o == '0));

    assert_ack_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
    import cfgport_pkg::*;
#(
    parameter int N_ENTRIES  = 8,
    parameter int DATA_BYTES = 4,
    parameter int OFF_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_i,
    input  logic                    wr_i,
    input  logic [1:0]              addr_i,
    input  logic [2:0]              size_i,
    input  logic [15:0]             wdata_i,
    output logic                    ack_o,
    output logic [DATA_BYTES*8-1:0] rdata_o
);

    acc_kind_t        kind;
    logic [15:0]      key;
    logic [OFF_W-1:0] off;
    logic [7:0]       fetch_byte;
    logic             fetch_valid;

    cfgport_decode #(.DATA_BYTES(DATA_BYTES)) u_decode (
        .wr_i   (wr_i),
        .addr_i (addr_i),
        .size_i (size_i),
        .kind_o (kind)
    );

    cfgport_table #(.N_ENTRIES(N_ENTRIES), .OFF_W(OFF_W)) u_table (
        .key_i   (key),
        .off_i   (off),
        .byte_o  (fetch_byte),
        .valid_o (fetch_valid)
    );

    cfgport_engine #(.N_ENTRIES(N_ENTRIES), .DATA_BYTES(DATA_BYTES), .OFF_W(OFF_W)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .kind_i       (kind),
        .size_i       (size_i),
        .wdata_i      (wdata_i),
        .byte_i       (fetch_byte),
        .byte_valid_i (fetch_valid),
        .key_o        (key),
        .off_o        (off),
        .ack_o        (ack_o),
        .rdata_o      (rdata_o)
    );

endmodule

// File: tb/keyed_cfg_port_bench.sv
module keyed_cfg_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [1:0]  addr_i = 2'd0;
    logic [2:0]  size_i = 3'd0;
    logic [15:0] wdata_i = 16'h0;
    logic        ack_o;
    logic [31:0] rdata_o;

    int tests = 0;
    int fails = 0;
    logic [15:0] mkey;
    int          moff;

    always #2 clk = ~clk;

    keyed_cfg_port u_keyed_cfg_port (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
        .size_i(size_i), .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o)
    );

    // Stimulus vectors: {wr, addr, size, wdata}
    localparam int NV = 27;
    localparam logic [21:0] VECS [NV] = '{
        {1'b1, 2'd0, 3'd2, 16'h0001}, {1'b0, 2'd1, 3'd1, 16'h0000},
        {1'b0, 2'd3, 3'd4, 16'h0000}, {1'b1, 2'd2, 3'd2, 16'h4003},
        {1'b0, 2'd3, 3'd2, 16'h0000}, {1'b0, 2'd3, 3'd3, 16'h0000},
        {1'b1, 2'd3, 3'd1, 16'h00AA}, {1'b1, 2'd1, 3'd1, 16'h0055},
        {1'b0, 2'd1, 3'd1, 16'h0000}, {1'b0, 2'd3, 3'd2, 16'h0000},
        {1'b1, 2'd0, 3'd2, 16'h0002}, {1'b0, 2'd3, 3'd4, 16'h0000},
        {1'b1, 2'd2, 3'd2, 16'h0008}, {1'b0, 2'd3, 3'd4, 16'h0000},
        {1'b1, 2'd0, 3'd2, 16'h8007}, {1'b0, 2'd3, 3'd4, 16'h0000},
        {1'b0, 2'd0, 3'd2, 16'h0000}, {1'b1, 2'd0, 3'd1, 16'h0005},
        {1'b0, 2'd2, 3'd2, 16'h0000}, {1'b0, 2'd3, 3'd0, 16'h0000},
        {1'b0, 2'd3, 3'd5, 16'h0000}, {1'b0, 2'd3, 3'd4, 16'h0000},
        {1'b0, 2'd1, 3'd1, 16'h0000}, {1'b1, 2'd2, 3'd2, 16'h4007},
        {1'b0, 2'd3, 3'd4, 16'h0000}, {1'b0, 2'd3, 3'd4, 16'h0000},
        {1'b0, 2'd3, 3'd4, 16'h0000}
    };

    function automatic int tb_len(int b, int e);
        if (e == 2) return 0;
        return e + 1 + b;
    endfunction

    function automatic int tb_base(int b, int e);
        int s = 0;
        for (int i = 0; i < b * 8 + e; i++) s += tb_len(i / 8, i % 8);
        return s;
    endfunction

    function automatic logic [7:0] tb_rom(int a);
        return 8'((a * 29 + 11) % 256);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Predicts the result of one access from the requirements and updates the model
    task automatic predict(input logic wr, input logic [1:0] addr, input logic [2:0] size,
                           input logic [15:0] wd, output logic [31:0] exp, output string tag);
        bit is_sel, is_rd;
        int b, e;
        logic [7:0] by;
        string view;
        is_sel = wr && size == 3'd2 && (addr == 2'd0 || addr == 2'd2);
        is_rd  = !wr && ((addr == 2'd1 && size == 3'd1) || (addr == 2'd3 && size >= 3'd1 && size <= 3'd4));
        view   = (addr < 2'd2) ? "R7" : "R8";
        exp    = 32'h0;
        if (is_sel) begin
            mkey = (wd[13:0] >= 14'd8) ? 16'hFFFF : wd;
            moff = 0;
            tag  = {"R2 ", view};
        end else if (is_rd) begin
            for (int i = 0; i < int'(size); i++) begin
                b = mkey[14] ? 1 : 0;
                e = int'(mkey[13:0]);
                if (mkey != 16'hFFFF && moff < tb_len(b, e)) begin
                    by = tb_rom(tb_base(b, e) + moff);
                    moff++;
                end else begin
                    by = 8'h00;
                end
                exp = (exp << 8) | {24'h0, by};
            end
            tag = {"R4 R5 R6 ", view};
        end else if (wr && (addr == 2'd1 || addr == 2'd3) && !(addr == 2'd3 && (size == 3'd0 || size > 3'd4)) && !(addr == 2'd1 && size != 3'd1)) begin
            tag = {"R9 ", view};
        end else begin
            tag = {"R10 ", view};
        end
    endtask

    task automatic access(input logic wr, input logic [1:0] addr, input logic [2:0] size,
                          input logic [15:0] wd, output logic [31:0] rd);
        int waited;
        @(negedge clk);
        req_i = 1'b1; wr_i = wr; addr_i = addr; size_i = size; wdata_i = wd;
        @(negedge clk);
        req_i = 1'b0;
        waited = 0;
        while (ack_o !== 1'b1 && waited < 64) begin
            @(negedge clk);
            waited++;
        end
        if (waited >= 64) begin
            tests++; fails++;
            $display("FAIL R12 actual=no ack expected=ack");
            rd = 32'hX;
        end else begin
            rd = rdata_o;
            @(negedge clk);
            check("R12 ack width", {31'h0, ack_o}, 32'h0);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mkey = 16'h0000;
        moff = 0;
    endtask

    initial begin
        logic [31:0] rd, exp;
        string tag;
        do_reset();
        check("R12 reset ack", {31'h0, ack_o}, 32'h0);
        check("R1 reset rdata", rdata_o, 32'h0);

        // R1: first read after reset comes from generic entry 0
        access(1'b0, 2'd1, 3'd1, 16'h0, rd);
        check("R1 key0 byte0", rd, 32'h0000000B);
        moff = 1;

        // Vector table walked against the model
        for (int v = 0; v < NV; v++) begin
            predict(VECS[v][21], VECS[v][20:19], VECS[v][18:16], VECS[v][15:0], exp, tag);
            access(VECS[v][21], VECS[v][20:19], VECS[v][18:16], VECS[v][15:0], rd);
            check(tag, rd, exp);
        end

        // R11: explicit table values for generic entry 1
        access(1'b1, 2'd0, 3'd2, 16'h0001, rd);
        access(1'b0, 2'd3, 3'd2, 16'h0, rd);
        check("R11 entry1 bytes", rd, 32'h00002845);

        // R3 R6: bit 15 ignored, bank bit picks local entry 0, tail reads zero
        access(1'b1, 2'd2, 3'd2, 16'hC000, rd);
        access(1'b0, 2'd3, 3'd4, 16'h0, rd);
        check("R3 R6 local entry0", rd, 32'hC8E50000);

        // R1: reset in the middle of a stream returns to key 0 offset 0
        access(1'b1, 2'd0, 3'd2, 16'h0005, rd);
        access(1'b0, 2'd1, 3'd1, 16'h0, rd);
        do_reset();
        access(1'b0, 2'd1, 3'd1, 16'h0, rd);
        check("R1 after re-reset", rd, 32'h0000000B);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        fails++;
        tests++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule